// File: doc/BRIEF.md
# Memory-Mapped Periodic Tick Timer

This block is a 32-bit periodic timer that sits behind a plain register port: one valid strobe, one write flag, a byte address and 32-bit data. While it is enabled it counts system-clock cycles, either undivided or divided by a power of two. When the count reaches the programmed period it returns to zero and raises a sticky status flag, which drives the interrupt line until software clears the flag.

The live count cannot be read directly. Software writes a request bit, polls that bit until hardware drops it, and then reads a latched copy of the count. The capture finishes a fixed number of cycles after the request, which models a synchronisation stage. The status flags share the control register with the enable bit and the divide field. They are cleared by writing ones to them, so software can clear them by writing ones and reading back until the field reads zero.

Top module: `tick_timer`

## Requirements
- R1: After reset the period register (offset 0) reads 0xFFFFFFFF. The control register (offset 12), the snapshot request (offset 16) and the snapshot value (offset 20) read 0, and `irq` is low.
- R2: Control bit 0 is the enable. While it is 0 the count and the prescaler hold their values. Setting it again resumes counting from the held values.
- R3: Control bits [5:3] hold a divide value N. A 7-bit prescaler resets to 0 and advances by one on each enabled cycle. A count tick happens on each enabled cycle in which the low N bits of the prescaler are all one, so N=0 gives a tick on every enabled cycle.
- R4: On each tick the count advances by one. On a tick where the count is greater than or equal to the period, the count becomes 0 and status bit 7 is set.
- R5: Control bits [9:7] are status flags. Writing 1 to a flag clears it and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves bit 7 set. Control bits 1, 2, 6 and [31:10] read 0.
- R6: The period register is read/write. Writing it also resets the count and the prescaler to 0 in that cycle, and no tick occurs in that cycle.
- R7: Writing 1 to bit 0 of offset 16 sets the busy bit, which reads back as bit 0. At the second clock edge after the request edge, the count as it stood before that edge is latched into offset 20 and busy clears. Requests made while busy, and writes of 0, have no effect.
- R8: `irq` is high exactly when any status flag in [9:7] is set. It follows the register edge that changes the flags.
- R9: `bus_rdata` returns the addressed register while `bus_valid` is high and `bus_write` is low, and 0 otherwise or for an unmapped offset. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt, high while any status flag is set |

## Verification
The timer is run with an undivided clock and a short period, so that wraps come back to back. It is also run with divide values 2 and 7 at small periods, which separates a correct prescaler phase from an off-by-one in the mask or the wrap compare. Snapshots are taken while the timer is running, while it is stopped, and with a second request sent while busy. These show that the captured value is the count from before the capture edge and that a request during busy is ignored. Status clears are issued with all-ones, with zeros and together with a wrap, which separates write-one-to-clear from plain write and shows that a set in the same cycle wins.

// File: rtl/tt_pkg.sv
package tt_pkg;

    localparam int DIV_W  = 3;
    localparam int STAT_W = 3;

    localparam int OFS_PERIOD   = 0;
    localparam int OFS_CTRL     = 12;
    localparam int OFS_SNAP_REQ = 16;
    localparam int OFS_SNAP_VAL = 20;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_DIV_LSB  = 3;
    localparam int CTRL_STAT_LSB = 7;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [DIV_W-1:0]  div;
        logic              en;
    } ctrl_t;

    typedef enum logic {
        SNAP_IDLE = 1'b0,
        SNAP_WAIT = 1'b1
    } snap_state_e;

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CTRL_EN_BIT] = c.en;
        w[CTRL_DIV_LSB +: DIV_W] = c.div;
        w[CTRL_STAT_LSB +: STAT_W] = c.stat;
        return w;
    endfunction

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler
    import tt_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clear,
    input  logic [DW-1:0] div,
    output logic          tick
);
    localparam int PRE_W = (1 << DW) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (i < int'(div));
    end

    assign tick = run && !clear && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_NODIV_EVERY: assert property (@(posedge clk) disable iff (rst)
        (run && !clear && div == '0) |-> tick); // R3

    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(pre_q)); // R2

endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] count_q;

    assign count = count_q;
    assign wrap  = tick && !clear && (count_q >= period);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= wrap ? '0 : count_q + 1'b1;
        end
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count_q == '0)); // R4

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clear) |=> $stable(count_q)); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !clear && !wrap) |=> (count_q == $past(count_q) + 1'b1)); // R4

endmodule

// File: rtl/tt_snapshot.sv
module tt_snapshot
    import tt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int SNAP_DELAY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] live,
    output logic             busy,
    output logic [CNT_W-1:0] value
);
    localparam int DLY_W = (SNAP_DELAY < 2) ? 1 : $clog2(SNAP_DELAY);
    localparam logic [DLY_W-1:0] LAST = DLY_W'(SNAP_DELAY - 1);

    snap_state_e      state_q;
    logic [DLY_W-1:0] wait_q;
    logic [CNT_W-1:0] value_q;

    assign busy  = (state_q == SNAP_WAIT);
    assign value = value_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SNAP_IDLE;
            wait_q  <= '0;
            value_q <= '0;
        end else begin
            unique case (state_q)
                SNAP_IDLE: begin
                    if (start) begin
                        state_q <= SNAP_WAIT;
                        wait_q  <= '0;
                    end
                end
                SNAP_WAIT: begin
                    if (wait_q == LAST) begin
                        value_q <= live;
                        state_q <= SNAP_IDLE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                default: state_q <= SNAP_IDLE;
            endcase
        end
    end

    AST_SNAP_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R7

    AST_SNAP_VALUE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (value_q == $past(live))); // R7

    AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(value_q)); // R7

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tt_pkg::*;
#(
    parameter int          DATA_W       = 32,
    parameter int          ADDR_W       = 8,
    parameter int          SNAP_DELAY   = 2,
    parameter logic [31:0] RESET_PERIOD = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFS_PERIOD);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_SREQ   = ADDR_W'(OFS_SNAP_REQ);
    localparam logic [ADDR_W-1:0] A_SVAL   = ADDR_W'(OFS_SNAP_VAL);

    logic [DATA_W-1:0] period_q;
    ctrl_t             ctrl_q;
    logic              wr_en, rd_en;
    logic              wr_period, wr_ctrl, wr_sreq;
    logic              tick, wrap;
    logic [DATA_W-1:0] count;
    logic              snap_busy;
    logic [DATA_W-1:0] snap_val;
    logic [STAT_W-1:0] stat_set;
    logic [STAT_W-1:0] stat_clr;
    logic [31:0]       ctrl_word;

    assign wr_en     = bus_valid && bus_write;
    assign rd_en     = bus_valid && !bus_write;
    assign wr_period = wr_en && (bus_addr == A_PERIOD);
    assign wr_ctrl   = wr_en && (bus_addr == A_CTRL);
    assign wr_sreq   = wr_en && (bus_addr == A_SREQ);

    tt_prescaler #(.DW(DIV_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl_q.en),
        .clear (wr_period),
        .div   (ctrl_q.div),
        .tick  (tick)
    );

    tt_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .clear  (wr_period),
        .period (period_q),
        .count  (count),
        .wrap   (wrap)
    );

    tt_snapshot #(.CNT_W(DATA_W), .SNAP_DELAY(SNAP_DELAY)) u_snap (
        .clk   (clk),
        .rst   (rst),
        .start (wr_sreq && bus_wdata[0]),
        .live  (count),
        .busy  (snap_busy),
        .value (snap_val)
    );

    assign stat_set = {{(STAT_W-1){1'b0}}, wrap};
    assign stat_clr = wr_ctrl ? bus_wdata[CTRL_STAT_LSB +: STAT_W] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= RESET_PERIOD;
            ctrl_q   <= '0;
        end else begin
            if (wr_period) begin
                period_q <= bus_wdata;
            end
            if (wr_ctrl) begin
                ctrl_q.en  <= bus_wdata[CTRL_EN_BIT];
                ctrl_q.div <= bus_wdata[CTRL_DIV_LSB +: DIV_W];
            end
            ctrl_q.stat <= (ctrl_q.stat & ~stat_clr) | stat_set;
        end
    end

    assign irq       = |ctrl_q.stat;
    assign ctrl_word = ctrl_to_word(ctrl_q);

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (bus_addr)
                A_PERIOD: bus_rdata = period_q;
                A_CTRL:   bus_rdata = DATA_W'(ctrl_word);
                A_SREQ:   bus_rdata = DATA_W'(snap_busy);
                A_SVAL:   bus_rdata = snap_val;
                default:  bus_rdata = '0;
            endcase
        end
    end

    AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        wrap |=> irq); // R8

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[CTRL_STAT_LSB] && !wrap) |=> !ctrl_q.stat[0]); // R5

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_ctrl) |=> irq); // R5

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !wr_period) |=> $stable(count)); // R2

    AST_PERIOD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_period |=> (count == '0)); // R6

endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr  = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference model
    logic [31:0] m_period, m_count, m_snap, old_count;
    int          m_pre, m_div, m_wait, step;
    bit          m_en, m_busy, tk, wp, pw, cw, sw;
    logic [2:0]  m_stat;

    always @(posedge clk) begin
        if (rst) begin
            m_period = 32'hFFFF_FFFF; m_count = 0; m_snap = 0; m_pre = 0;
            m_div = 0; m_wait = 0; m_en = 0; m_busy = 0; m_stat = 0;
        end else begin
            pw = bus_valid && bus_write && bus_addr == 8'd0;
            cw = bus_valid && bus_write && bus_addr == 8'd12;
            sw = bus_valid && bus_write && bus_addr == 8'd16;
            step = 1 << m_div;
            tk = m_en && !pw && ((m_pre % step) == step - 1);
            wp = tk && (m_count >= m_period);
            old_count = m_count;
            if (m_busy) begin
                if (m_wait == 1) begin m_snap = old_count; m_busy = 0; end
                else m_wait = m_wait + 1;
            end else if (sw && bus_wdata[0]) begin
                m_busy = 1; m_wait = 0;
            end
            if (pw) begin
                m_count = 0; m_pre = 0;
            end else begin
                if (m_en) m_pre = (m_pre + 1) % 128;
                if (tk) m_count = wp ? 32'd0 : m_count + 1;
            end
            if (cw) begin
                m_stat = m_stat & ~bus_wdata[9:7];
                m_en   = bus_wdata[0];
                m_div  = int'(bus_wdata[5:3]);
            end
            if (wp) m_stat[0] = 1'b1;
            if (pw) m_period = bus_wdata;
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] w;
        w = 0;
        case (a)
            8'd0:  w = m_period;
            8'd12: begin w[0] = m_en; w[5:3] = m_div[2:0]; w[9:7] = m_stat; end
            8'd16: w[0] = m_busy;
            8'd20: w = m_snap;
            default: w = 0;
        endcase
        return w;
    endfunction

    // R8: interrupt line compared on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (irq !== (m_stat != 0)) begin
                fails++;
                $display("FAIL R8 irq actual=%0b expected=%0b at %0t", irq, (m_stat != 0), $time);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1;
        check(tag, bus_rdata, model_read(a));
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic snapshot(input string tag);
        wr(8'd16, 32'd1);
        rd(8'd16, tag);
        for (int i = 0; i < 8; i++) begin
            rd(8'd16, tag);
            if (bus_rdata[0] == 1'b0) break;
        end
        rd(8'd20, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset values
        check("R1 period", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd(8'd0,  "R1 period");
        rd(8'd12, "R1 ctrl");
        rd(8'd16, "R1 sreq");
        rd(8'd20, "R1 sval");
        check("R1 irq", {31'd0, irq}, 32'd0);
        // R9 unmapped and non-read
        wr(8'd4, 32'hDEAD_BEEF);
        rd(8'd4, "R9 unmapped");
        rd(8'd0, "R9 period after unmapped write");
        @(negedge clk); bus_valid = 0; bus_addr = 8'd0; #1;
        check("R9 no read", bus_rdata, 32'd0);
        // R6 R4 undivided run with short period
        wr(8'd0, 32'd5);
        rd(8'd0, "R6 period");
        wr(8'd12, 32'h0000_0001);
        idle(20);
        rd(8'd12, "R4 ctrl status after wraps");
        snapshot("R7 snapshot running");
        // R5 write zeros leaves status, ones clear
        wr(8'd12, 32'h0000_0001);
        rd(8'd12, "R5 write zero keeps");
        wr(8'd12, 32'h0000_0381);
        rd(8'd12, "R5 w1c");
        for (int k = 0; k < 8; k++) begin
            wr(8'd12, 32'h0000_0381);
            rd(8'd12, "R5 clear with wrap");
        end
        // R2 disable holds
        wr(8'd12, 32'h0000_0380);
        snapshot("R2 stopped a");
        idle(12);
        snapshot("R2 stopped b");
        wr(8'd12, 32'h0000_0001);
        idle(7);
        snapshot("R2 resumed");
        // R3 divide by 4
        wr(8'd12, 32'h0000_0380);
        wr(8'd0, 32'd3);
        wr(8'd12, 32'h0000_0011);
        idle(37);
        rd(8'd12, "R3 div4 ctrl");
        snapshot("R3 div4 snapshot");
        // R7 request while busy and write of zero
        wr(8'd16, 32'd1);
        wr(8'd16, 32'd1);
        rd(8'd16, "R7 busy");
        idle(3);
        rd(8'd20, "R7 value after double request");
        wr(8'd16, 32'd0);
        rd(8'd16, "R7 zero write");
        // R3 divide by 128
        wr(8'd12, 32'h0000_0380);
        wr(8'd0, 32'd1);
        wr(8'd12, 32'h0000_0039);
        idle(300);
        rd(8'd12, "R3 div128 ctrl");
        snapshot("R3 div128 snapshot");
        // R6 period write mid-run clears count
        wr(8'd0, 32'd100);
        snapshot("R6 cleared by period write");
        rd(8'd12, "R6 ctrl");
        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule